// File: doc/BRIEF.md
# Interrupt-Driven Register Page Stack

This block sits between a small 8-bit core and its special-function register space. The space is larger than the 8-bit address can reach, so part of it is banked into pages. A three-slot page stack holds the active page, the page to return to, and the page below that. When the core takes an interrupt, the block can move the stack down one slot and load the active slot with a page that the interrupt source supplies. The handler then finds its own registers without any page-select code. On interrupt return the stack moves back up.

A control bit turns this automatic switching on or off. It comes out of reset set. Software can also read and write each stack slot directly. A group of addresses stays visible whatever the active page holds: four general I/O registers, the control register and the three stack slots. A window of addresses is decoded against the active page. It reaches a per-page register store that is laid out as an inferable RAM. Any other address, or a window access while the active page has no store behind it, is unmapped.

Top module: `regpage_ctrl`

## Requirements
- R1: After a synchronous reset the active, return and lower slots read 0x00, the auto-switch bit reads 1 and the four I/O registers read 0x00.
- R2: When auto-switching is on and `irq_enter` is high, the next edge loads the active slot with `irq_page`, the return slot with the old active value and the lower slot with the old return value.
- R3: When auto-switching is on and `irq_return` is high with `irq_enter` low, the next edge loads the active slot from the return slot and the return slot from the lower slot. The lower slot keeps its value.
- R4: When auto-switching is off, `irq_enter` and `irq_return` leave all three slots unchanged.
- R5: When `irq_enter` and `irq_return` are both high in one cycle, only the entry (R2) takes effect.
- R6: A bus write to address 0x85, 0x86 or 0x87 sets the active, return or lower slot. A write to 0x84 sets the auto-switch bit from data bit 0. A read of 0x84 returns the bit in bit 0 and zeros in the other bits.
- R7: In a cycle where an automatic entry or return takes effect, a bus write to any of the three slot addresses is dropped. A write to 0x84 in the same cycle still applies, and the switch in that cycle uses the old bit value.
- R8: Addresses 0x80 to 0x83 (I/O registers) and 0x84 to 0x87 reach the same storage whatever the active page holds. The I/O register contents drive `io_q`, with register k at bits 8k+7 to 8k.
- R9: Addresses 0xC0 to 0xC7 reach the store of the active page when that page is below 4, using the page value held before the edge. Pages 4 and above leave the window unmapped.
- R10: A read of an unmapped address returns 0x00 with `bus_hit` low. A write to an unmapped address changes nothing.
- R11: `bus_rdata` and `bus_hit` are valid in the cycle after the access. `bus_rdata` is 0x00 after a cycle with no read, and `bus_hit` is low after a cycle with neither a read nor a write. A read and a write in the same cycle return the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_enter | input | 1 | Interrupt-taken strobe, one cycle |
| irq_return | input | 1 | Interrupt-return strobe, one cycle |
| irq_page | input | 8 | Page that belongs to the interrupting source |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after `bus_rd` |
| bus_hit | output | 1 | The previous access reached a mapped register |
| cur_page | output | 8 | Active page slot |
| auto_en | output | 1 | Automatic switching enabled |
| io_q | output | 32 | The four I/O registers, concatenated |

## Verification
The bench goes after the points where the slots move against each other:
- Two nested entries followed by two returns. A design that dropped the lower slot would return to a wrong page on the second return.
- Entry and return in the same cycle. A design that let the return win would leave the handler's page unloaded.
- A slot write in the same cycle as a switch. Letting software win would corrupt the nesting.
- A control write in the same cycle as a strobe.
- The page used for a window access in the same edge as a push. Using the new page there would hit the wrong bank.
- Window accesses on pages 4 and above, and I/O accesses from several pages. A design that decoded the all-pages group through the page would return stale or zero data on those.

// File: rtl/regpage_pkg.sv
package regpage_pkg;
  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_IO    = 3'd1,
    K_CTL   = 3'd2,
    K_STK   = 3'd3,
    K_PAGED = 3'd4
  } acc_kind_e;

  function automatic int bits_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/regpage_decode.sv
module regpage_decode
  import regpage_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int IO_BASE   = 'h80,
  parameter int IO_CNT    = 4,
  parameter int WIN_BASE  = 'hC0,
  parameter int WIN_SIZE  = 8,
  parameter int NUM_PAGES = 4,
  parameter int IDX_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] page,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  localparam int CTL_ADDR = IO_BASE + IO_CNT;
  localparam int STK_BASE = CTL_ADDR + 1;

  int a_i;
  int p_i;
  assign a_i = int'(addr);
  assign p_i = int'(page);

  always_comb begin
    kind = K_NONE;
    idx  = '0;
    if (a_i >= IO_BASE && a_i < IO_BASE + IO_CNT) begin
      kind = K_IO;
      idx  = IDX_W'(a_i - IO_BASE);
    end else if (a_i == CTL_ADDR) begin
      kind = K_CTL;
    end else if (a_i >= STK_BASE && a_i < STK_BASE + 3) begin
      kind = K_STK;
      idx  = IDX_W'(a_i - STK_BASE);
    end else if (a_i >= WIN_BASE && a_i < WIN_BASE + WIN_SIZE && p_i < NUM_PAGES) begin
      kind = K_PAGED;
      idx  = IDX_W'(a_i - WIN_BASE);
    end
  end

  // R9: no window decode on a page that has no store behind it
  assert_no_window_on_high_page_R9: assert property (@(posedge clk) disable iff (rst)
    (p_i >= NUM_PAGES) |-> (kind != K_PAGED));
  // R8: all-pages group decodes independent of the page value
  assert_global_ignores_page_R8: assert property (@(posedge clk) disable iff (rst)
    (a_i >= IO_BASE && a_i < IO_BASE + IO_CNT) |-> (kind == K_IO));
endmodule

// File: rtl/regpage_stack.sv
module regpage_stack #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_enter,
  input  logic              irq_return,
  input  logic [DATA_W-1:0] irq_page,
  input  logic              ctl_we,
  input  logic              ctl_bit,
  input  logic              stk_we,
  input  logic [1:0]        stk_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cur_q,
  output logic [DATA_W-1:0] nxt_q,
  output logic [DATA_W-1:0] lst_q,
  output logic              auto_q
);
  logic push, pop;
  assign push = irq_enter & auto_q;
  assign pop  = irq_return & auto_q & ~irq_enter;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      nxt_q  <= '0;
      lst_q  <= '0;
      auto_q <= 1'b1;
    end else begin
      if (ctl_we) auto_q <= ctl_bit;
      if (push) begin
        cur_q <= irq_page;
        nxt_q <= cur_q;
        lst_q <= nxt_q;
      end else if (pop) begin
        cur_q <= nxt_q;
        nxt_q <= lst_q;
      end else if (stk_we) begin
        case (stk_sel)
          2'd0:    cur_q <= wdata;
          2'd1:    nxt_q <= wdata;
          default: lst_q <= wdata;
        endcase
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cur_q == '0 && nxt_q == '0 && lst_q == '0 && auto_q));
  assert_push_shift_R2: assert property (@(posedge clk) disable iff (rst)
    (irq_enter && auto_q) |=> (cur_q == $past(irq_page) && nxt_q == $past(cur_q) && lst_q == $past(nxt_q)));
  assert_pop_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (irq_return && !irq_enter && auto_q) |=> (cur_q == $past(nxt_q) && nxt_q == $past(lst_q) && $stable(lst_q)));
  assert_disabled_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!auto_q && !stk_we) |=> ($stable(cur_q) && $stable(nxt_q) && $stable(lst_q)));
  assert_sw_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (pop && stk_we) |=> $stable(lst_q));
endmodule

// File: rtl/regpage_store.sv
module regpage_store
  import regpage_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int IO_CNT    = 4,
  parameter int WIN_SIZE  = 8,
  parameter int NUM_PAGES = 4,
  parameter int IDX_W     = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     io_we,
  input  logic                     mem_we,
  input  logic [IDX_W-1:0]         idx,
  input  logic [DATA_W-1:0]        page,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        mem_q,
  output logic [DATA_W-1:0]        io_rd,
  output logic [IO_CNT*DATA_W-1:0] io_flat
);
  localparam int DEPTH = NUM_PAGES * WIN_SIZE;
  localparam int MA_W  = bits_for(DEPTH);
  localparam int IO_W  = bits_for(IO_CNT);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] io_r [IO_CNT];
  logic [MA_W-1:0]   maddr;
  int                lin;

  assign lin   = int'(page) * WIN_SIZE + int'(idx);
  assign maddr = MA_W'(lin);

  always_ff @(posedge clk) begin
    if (mem_we) mem[maddr] <= wdata;
    mem_q <= mem[maddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < IO_CNT; k++) io_r[k] <= '0;
    end else if (io_we) begin
      io_r[IO_W'(idx)] <= wdata;
    end
  end

  assign io_rd = io_r[IO_W'(idx)];

  for (genvar g = 0; g < IO_CNT; g++) begin : g_io
    assign io_flat[g*DATA_W +: DATA_W] = io_r[g];
  end
endmodule

// File: rtl/regpage_ctrl.sv
module regpage_ctrl
  import regpage_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int IO_BASE   = 'h80,
  parameter int IO_CNT    = 4,
  parameter int WIN_BASE  = 'hC0,
  parameter int WIN_SIZE  = 8,
  parameter int NUM_PAGES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     irq_enter,
  input  logic                     irq_return,
  input  logic [DATA_W-1:0]        irq_page,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_hit,
  output logic [DATA_W-1:0]        cur_page,
  output logic                     auto_en,
  output logic [IO_CNT*DATA_W-1:0] io_q
);
  localparam int MAXN  = (IO_CNT > WIN_SIZE) ? IO_CNT : WIN_SIZE;
  localparam int IDX_W = bits_for((MAXN > 4) ? MAXN : 4);

  acc_kind_e         kind, kind_q;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] cur_q, nxt_q, lst_q, mem_q, io_rd, glob_val, glob_q;
  logic              auto_q, hit_q;

  regpage_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_BASE(IO_BASE), .IO_CNT(IO_CNT),
    .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE), .NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)
  ) u_dec (
    .clk(clk), .rst(rst), .addr(bus_addr), .page(cur_q), .kind(kind), .idx(idx)
  );

  regpage_stack #(.DATA_W(DATA_W)) u_stk (
    .clk(clk), .rst(rst), .irq_enter(irq_enter), .irq_return(irq_return),
    .irq_page(irq_page),
    .ctl_we(bus_wr && kind == K_CTL), .ctl_bit(bus_wdata[0]),
    .stk_we(bus_wr && kind == K_STK), .stk_sel(idx[1:0]), .wdata(bus_wdata),
    .cur_q(cur_q), .nxt_q(nxt_q), .lst_q(lst_q), .auto_q(auto_q)
  );

  regpage_store #(
    .DATA_W(DATA_W), .IO_CNT(IO_CNT), .WIN_SIZE(WIN_SIZE),
    .NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)
  ) u_st (
    .clk(clk), .rst(rst),
    .io_we(bus_wr && kind == K_IO), .mem_we(bus_wr && kind == K_PAGED),
    .idx(idx), .page(cur_q), .wdata(bus_wdata),
    .mem_q(mem_q), .io_rd(io_rd), .io_flat(io_q)
  );

  always_comb begin
    glob_val = '0;
    case (kind)
      K_IO:  glob_val = io_rd;
      K_CTL: glob_val = {{(DATA_W-1){1'b0}}, auto_q};
      K_STK: glob_val = (idx[1:0] == 2'd0) ? cur_q : (idx[1:0] == 2'd1) ? nxt_q : lst_q;
      default: glob_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= K_NONE;
      glob_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      kind_q <= bus_rd ? kind : K_NONE;
      glob_q <= glob_val;
      hit_q  <= (bus_rd || bus_wr) && (kind != K_NONE);
    end
  end

  assign bus_rdata = (kind_q == K_PAGED) ? mem_q : (kind_q == K_NONE) ? '0 : glob_q;
  assign bus_hit   = hit_q;
  assign cur_page  = cur_q;
  assign auto_en   = auto_q;

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
  assert_idle_nohit_R11: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd || bus_wr) |=> !bus_hit);
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_hit |-> (bus_rdata == '0));
endmodule

// File: tb/regpage_ctrl_tb_top.sv
module regpage_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_enter = 0, irq_return = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] irq_page = 0, bus_addr = 0, bus_wdata = 0;
  logic [7:0] bus_rdata, cur_page;
  logic bus_hit, auto_en;
  logic [31:0] io_q;

  int n_checks = 0, n_fail = 0, cycles = 0;
  string tag = "R1";
  bit started = 0;

  // reference model state
  int m_mem [32];
  int m_io [4];
  int m_cur = 0, m_nxt = 0, m_lst = 0, m_au = 1, e_rd = 0, e_hit = 0;

  always #2.5 clk = ~clk;

  regpage_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_enter(irq_enter), .irq_return(irq_return),
    .irq_page(irq_page), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_hit(bus_hit),
    .cur_page(cur_page), .auto_en(auto_en), .io_q(io_q)
  );

  function automatic int mread(input int a);
    if (a >= 'h80 && a <= 'h83) return m_io[a - 'h80];
    if (a == 'h84) return m_au;
    if (a == 'h85) return m_cur;
    if (a == 'h86) return m_nxt;
    if (a == 'h87) return m_lst;
    if (a >= 'hC0 && a <= 'hC7 && m_cur < 4) return m_mem[m_cur * 8 + a - 'hC0];
    return -1;
  endfunction

  always @(posedge clk) begin : model
    int v;
    bit push, pop;
    started = 1;
    if (rst) begin
      m_cur = 0; m_nxt = 0; m_lst = 0; m_au = 1; e_rd = 0; e_hit = 0;
      for (int k = 0; k < 4; k++) m_io[k] = 0;
    end else begin
      v = mread(int'(bus_addr));
      e_hit = ((bus_rd || bus_wr) && v >= 0) ? 1 : 0;
      e_rd  = (bus_rd && v >= 0) ? v : 0;
      push = irq_enter && m_au != 0;
      pop  = irq_return && m_au != 0 && !irq_enter;
      if (bus_wr) begin
        if (bus_addr >= 8'h80 && bus_addr <= 8'h83) m_io[bus_addr - 8'h80] = int'(bus_wdata);
        else if (bus_addr == 8'h84) m_au = int'(bus_wdata[0]);
        else if (!(push || pop) && bus_addr == 8'h85) m_cur = int'(bus_wdata);
        else if (!(push || pop) && bus_addr == 8'h86) m_nxt = int'(bus_wdata);
        else if (!(push || pop) && bus_addr == 8'h87) m_lst = int'(bus_wdata);
        else if (bus_addr >= 8'hC0 && bus_addr <= 8'hC7 && m_cur < 4)
          m_mem[m_cur * 8 + int'(bus_addr) - 'hC0] = int'(bus_wdata);
      end
      if (push) begin
        m_lst = m_nxt; m_nxt = m_cur; m_cur = int'(irq_page);
      end else if (pop) begin
        m_cur = m_nxt; m_nxt = m_lst;
      end
    end
  end

  task automatic check(input string t, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      check(tag, "cur_page", int'(cur_page), m_cur);
      check(tag, "auto_en", int'(auto_en), m_au);
      check(tag, "bus_rdata", int'(bus_rdata), e_rd);
      check(tag, "bus_hit", int'(bus_hit), e_hit);
      for (int k = 0; k < 4; k++) check(tag, "io_q", int'(io_q[k*8 +: 8]), m_io[k]);
    end
  end

  task automatic drive(input bit rd, input bit wr, input int a, input int d,
                       input bit en, input bit rt, input int pg);
    @(negedge clk); #1;
    bus_rd = rd; bus_wr = wr; bus_addr = 8'(a); bus_wdata = 8'(d);
    irq_enter = en; irq_return = rt; irq_page = 8'(pg);
    @(negedge clk); #1;
    bus_rd = 0; bus_wr = 0; irq_enter = 0; irq_return = 0;
  endtask

  task automatic wr(input int a, input int d); drive(0, 1, a, d, 0, 0, 0); endtask
  task automatic rd(input int a);              drive(1, 0, a, 0, 0, 0, 0); endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;
    @(negedge clk);
    tag = "R1";
    check("R1", "reset cur", int'(cur_page), 0);
    check("R1", "reset auto", int'(auto_en), 1);
    check("R1", "reset io", int'(io_q), 0);
    rd('h86); rd('h87);

    tag = "R9";
    for (int p = 0; p < 4; p++) begin
      wr('h85, p);
      for (int o = 0; o < 8; o++) wr('hC0 + o, 16 * p + o + 1);
    end
    for (int p = 0; p < 6; p++) begin
      wr('h85, p);
      for (int o = 0; o < 8; o += 3) rd('hC0 + o);
    end
    wr('h85, 5); wr('hC2, 'hEE);
    wr('h85, 2); rd('hC2);
    check("R9", "page2 window", int'(bus_rdata), 'h23);

    tag = "R8";
    for (int k = 0; k < 4; k++) wr('h80 + k, 'hA0 + k);
    for (int p = 0; p < 8; p += 7) begin
      wr('h85, p);
      for (int k = 0; k < 8; k++) rd('h80 + k);
    end
    check("R8", "io on page7", int'(io_q), 'hA3A2A1A0);

    tag = "R2";
    wr('h85, 0);
    drive(0, 0, 0, 0, 1, 0, 1);
    drive(1, 0, 'hC1, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 0, 3);
    rd('h86); rd('h87); rd('hC0);
    check("R2", "nested cur", int'(cur_page), 3);
    drive(1, 1, 'hC4, 'h77, 1, 0, 2);   // access uses pre-push page 3
    rd('hC4);

    tag = "R3";
    drive(0, 0, 0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 0, 1, 0);
    rd('h87);
    check("R3", "after two pops", int'(cur_page), 1);
    drive(0, 0, 0, 0, 0, 1, 0);
    rd('h85); rd('h86);

    tag = "R4";
    wr('h84, 0);
    drive(0, 0, 0, 0, 1, 0, 2);
    drive(0, 0, 0, 0, 0, 1, 0);
    check("R4", "disabled hold", int'(cur_page), m_cur);
    wr('h85, 6); rd('h85);
    drive(0, 1, 'h84, 1, 1, 0, 2);   // write enables, push uses old bit
    check("R4", "old bit used", int'(cur_page), 6);

    tag = "R5";
    drive(0, 0, 0, 0, 1, 1, 9);
    check("R5", "entry wins", int'(cur_page), 9);
    rd('h86);

    tag = "R7";
    drive(0, 1, 'h85, 'h55, 1, 0, 2);
    check("R7", "push beats sw", int'(cur_page), 2);
    drive(0, 1, 'h87, 'h44, 0, 1, 0);
    rd('h87); rd('h86);
    drive(0, 1, 'h84, 0, 1, 0, 3);   // control write applies alongside push
    check("R7", "ctl with push", int'(auto_en), 0);

    tag = "R6";
    wr('h86, 'h5A); wr('h87, 'hA5); wr('h85, 'h12);
    rd('h85); rd('h86); rd('h87);
    wr('h84, 'hFF); rd('h84);
    check("R6", "ctl read", int'(bus_rdata), 1);
    wr('h84, 'hFE); rd('h84);
    check("R6", "ctl cleared", int'(auto_en), 0);
    wr('h84, 1);

    tag = "R10";
    wr('h85, 1);
    wr('h10, 'hFF); wr('h88, 'hFF); wr('hC8, 'hFF);
    rd('h10); rd('h88); rd('hC8); rd('h7F);
    check("R10", "unmapped hit", int'(bus_hit), 0);
    for (int o = 0; o < 8; o++) rd('hC0 + o);

    tag = "R11";
    drive(1, 1, 'h81, 'h3C, 0, 0, 0);
    check("R11", "rd+wr old value", int'(bus_rdata), 'hA1);
    rd('h81);
    repeat (3) @(negedge clk);
    check("R11", "idle rdata", int'(bus_rdata), 0);
    check("R11", "idle hit", int'(bus_hit), 0);

    @(negedge clk);
    finish_run();
  end
endmodule